// File: doc/BRIEF.md
# Stereo Serial Audio Output Master

This block drives the master side of a two-channel serial audio link from a single master clock. It generates a word clock at the sample rate, a bit clock and a frame-sync strobe, and serializes a left and a right sample word per frame in one of five bit formats. The word clock is high while the left word is sent and low while the right word is sent. A one-cycle sample-request pulse marks the start of each frame.

The host supplies 18-bit left and right samples together with a load strobe. The 16-bit formats use the upper 16 bits. A word pair loaded during one frame is sent in the next frame. Format, clock ratio and frame-sync style are sampled once per frame at its first master-clock cycle, so a change never splits a frame.

All outputs come from registers and change together. Serial data, frame sync and word clock change only where the bit clock is low, which leaves the bit clock's rising edge free for the receiver to sample them.

Top module: `aser_master`

## Requirements
- R1: While `rst_i` is high every output is low; in the first master-clock cycle after release the word clock is high and the request pulse is present.
- R2: The word-clock period is 256 master clocks when `ratio_sel_i` is 0 and 384 when it is 1. The clock is high for the first half of the frame (left word) and low for the second half (right word).
- R3: Formats 3 and 4 use 32 bit-clock periods per frame; every other code uses 64. The bit clock is low for the first half and high for the second half of each bit period (master-clock divide 4, 6, 8 or 12), and serial data, frame sync and word clock change only while it is low.
- R4: `req_o` is high for exactly one master clock, in the cycle the word clock rises. A pair loaded with `load_i` is sent in the following frame, and the first frame after reset sends zero words.
- R5: Format 0 sends the 18-bit word MSB first in bit slots 0 to 17 of each half.
- R6: Format 1 sends the 18-bit word LSB first and right-justified, in slots 14 to 31 of each half.
- R7: Format 2 sends sample bits 17 down to 2 MSB first in slots 1 to 16 of each half.
- R8: Format 3 sends sample bits 17 down to 2 MSB first in slots 0 to 15 of each 16-slot half.
- R9: Format 4 sends sample bits 2 up to 17 LSB first in slots 0 to 15 of each 16-slot half.
- R10: Slots that carry no data bit output 0. Codes 5, 6 and 7 behave as format 0.
- R11: With `fs_level_i` at 0, frame sync is high for exactly the one bit slot just before the first data slot of each half. For formats 0, 3 and 4 that slot is the last slot of the previous half.
- R12: With `fs_level_i` at 1, frame sync is high in exactly the slots that carry data bits.
- R13: Format, ratio and frame-sync style changes take effect at the next rise of the word clock, never within a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ratio_sel_i | input | 1 | Frame length select: 0 for 256 master clocks, 1 for 384 |
| fmt_sel_i | input | 3 | Serial format code 0 to 4 (5 to 7 act as 0) |
| fs_level_i | input | 1 | Frame-sync style: 0 single pulse, 1 level over the data bits |
| load_i | input | 1 | Captures the sample pair for the next frame |
| left_i | input | 18 | Left sample word |
| right_i | input | 18 | Right sample word |
| wclk_o | output | 1 | Word clock at the sample rate |
| bclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame sync |
| sdata_o | output | 1 | Serial data |
| req_o | output | 1 | One-cycle sample request at each frame start |

## Verification
Every output sits one master clock behind the internal bit-phase and slot counters. The bench therefore compares all five outputs at each falling clock edge against a model stepped once per cycle from the release of reset, so cycle n of the model is compared with the outputs after rising edge n. A new sample pair, format or ratio enters the model only at the step after the last cycle of a frame, the same point where the design latches it. The checks then show a one-frame delay for loaded words and no effect on a frame already in progress. Mismatches are gathered per signal over each scenario and reported with the first failing cycle.

// File: rtl/aser_pkg.sv
`timescale 1ns/1ps
package aser_pkg;

  typedef enum logic [2:0] {
    FMT_L18_MSB   = 3'd0,
    FMT_R18_LSB   = 3'd1,
    FMT_D16_MSB   = 3'd2,
    FMT_N16_MSB   = 3'd3,
    FMT_N16_LSB   = 3'd4
  } fmt_e;

  typedef struct packed {
    logic narrow;      // 32 bit slots per frame instead of 64
    logic lsb_first;   // right-justified, least significant bit first
    logic short_word;  // upper bits of the sample only
    logic delayed;     // first bit one slot after the word-clock edge
  } fmt_cfg_t;

  function automatic fmt_cfg_t fmt_decode(input logic [2:0] code);
    fmt_cfg_t c;
    c = '0;
    case (code)
      FMT_R18_LSB: c.lsb_first = 1'b1;
      FMT_D16_MSB: begin c.short_word = 1'b1; c.delayed = 1'b1; end
      FMT_N16_MSB: begin c.narrow = 1'b1; c.short_word = 1'b1; end
      FMT_N16_LSB: begin c.narrow = 1'b1; c.short_word = 1'b1; c.lsb_first = 1'b1; end
      default:     c = '0;
    endcase
    return c;
  endfunction

  function automatic logic fmt_is_narrow(input logic [2:0] code);
    return (code == FMT_N16_MSB) || (code == FMT_N16_LSB);
  endfunction

endpackage

// File: rtl/aser_timebase.sv
`timescale 1ns/1ps
module aser_timebase
  import aser_pkg::*;
#(
  parameter int FRAME_LO     = 256,
  parameter int FRAME_HI     = 384,
  parameter int SLOTS_WIDE   = 64,
  parameter int SLOTS_NARROW = 32,
  parameter int SLOT_W       = $clog2(SLOTS_WIDE)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              ratio_sel_i,
  input  logic [2:0]        fmt_sel_i,
  input  logic              fs_level_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [2:0]        act_fmt_o,
  output logic              act_lvl_o,
  output logic              left_half_o,
  output logic              bclk_lvl_o,
  output logic              frame_start_o,
  output logic              frame_end_o
);

  localparam int PER_WL = FRAME_LO / SLOTS_WIDE;
  localparam int PER_WH = FRAME_HI / SLOTS_WIDE;
  localparam int PER_NL = FRAME_LO / SLOTS_NARROW;
  localparam int PER_NH = FRAME_HI / SLOTS_NARROW;
  localparam int PH_W   = $clog2(PER_NH + 1);

  logic [PH_W-1:0]   ph_q;
  logic [SLOT_W-1:0] slot_q;
  logic [2:0]        fmt_q;
  logic              ratio_q;
  logic              lvl_q;

  logic [PH_W-1:0]   per;
  logic [SLOT_W-1:0] last_slot;
  logic [SLOT_W-1:0] half;
  logic              narrow;
  logic              ph_last;

  always_comb begin
    narrow = fmt_is_narrow(fmt_q);
    case ({narrow, ratio_q})
      2'b00:   per = PH_W'(PER_WL);
      2'b01:   per = PH_W'(PER_WH);
      2'b10:   per = PH_W'(PER_NL);
      default: per = PH_W'(PER_NH);
    endcase
    last_slot   = narrow ? SLOT_W'(SLOTS_NARROW - 1) : SLOT_W'(SLOTS_WIDE - 1);
    half        = narrow ? SLOT_W'(SLOTS_NARROW / 2) : SLOT_W'(SLOTS_WIDE / 2);
    ph_last     = (ph_q == per - 1'b1);
    frame_end_o = ph_last && (slot_q == last_slot);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ph_q    <= '0;
      slot_q  <= '0;
      fmt_q   <= fmt_sel_i;
      ratio_q <= ratio_sel_i;
      lvl_q   <= fs_level_i;
    end else if (ph_last) begin
      ph_q <= '0;
      if (frame_end_o) begin
        slot_q  <= '0;
        fmt_q   <= fmt_sel_i;
        ratio_q <= ratio_sel_i;
        lvl_q   <= fs_level_i;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign slot_o        = slot_q;
  assign act_fmt_o     = fmt_q;
  assign act_lvl_o     = lvl_q;
  assign left_half_o   = (slot_q < half);
  assign bclk_lvl_o    = (ph_q >= (per >> 1));
  assign frame_start_o = (ph_q == '0) && (slot_q == '0);

endmodule

// File: rtl/aser_sample_hold.sv
`timescale 1ns/1ps
module aser_sample_hold #(
  parameter int SAMPLE_W = 18
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                load_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                swap_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);

  logic [SAMPLE_W-1:0] pend_l_q, pend_r_q;
  logic [SAMPLE_W-1:0] act_l_q, act_r_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pend_l_q <= '0;
      pend_r_q <= '0;
      act_l_q  <= '0;
      act_r_q  <= '0;
    end else begin
      if (load_i) begin
        pend_l_q <= left_i;
        pend_r_q <= right_i;
      end
      if (swap_i) begin
        act_l_q <= load_i ? left_i  : pend_l_q;
        act_r_q <= load_i ? right_i : pend_r_q;
      end
    end
  end

  assign left_o  = act_l_q;
  assign right_o = act_r_q;

endmodule

// File: rtl/aser_slot_map.sv
`timescale 1ns/1ps
module aser_slot_map
  import aser_pkg::*;
#(
  parameter int SAMPLE_W     = 18,
  parameter int NARROW_W     = 16,
  parameter int SLOTS_WIDE   = 64,
  parameter int SLOTS_NARROW = 32,
  parameter int SLOT_W       = $clog2(SLOTS_WIDE)
) (
  input  logic [SLOT_W-1:0]   slot_i,
  input  logic                left_half_i,
  input  logic [2:0]          fmt_i,
  input  logic                fs_level_i,
  input  logic [SAMPLE_W-1:0] left_w_i,
  input  logic [SAMPLE_W-1:0] right_w_i,
  output logic                sd_o,
  output logic                fs_o
);

  localparam int IDX_W = $clog2(SAMPLE_W);

  fmt_cfg_t            cfg;
  int                  half, wlen, start, s_loc, k, nxt;
  logic                valid;
  logic [IDX_W-1:0]    idx;
  logic [SAMPLE_W-1:0] word;

  always_comb begin
    cfg  = fmt_decode(fmt_i);
    half = cfg.narrow ? SLOTS_NARROW / 2 : SLOTS_WIDE / 2;
    wlen = cfg.short_word ? NARROW_W : SAMPLE_W;
    if (cfg.lsb_first)    start = half - wlen;
    else if (cfg.delayed) start = 1;
    else                  start = 0;
    s_loc = left_half_i ? int'(slot_i) : int'(slot_i) - half;
    k     = s_loc - start;
    valid = (k >= 0) && (k < wlen);
    word  = left_half_i ? left_w_i : right_w_i;
    if (!valid)             idx = '0;
    else if (cfg.lsb_first) idx = IDX_W'(SAMPLE_W - wlen + k);
    else                    idx = IDX_W'(SAMPLE_W - 1 - k);
    nxt  = (s_loc + 1 == half) ? 0 : s_loc + 1;
    sd_o = valid && word[idx];
    fs_o = fs_level_i ? valid : (nxt == start);
  end

endmodule

// File: rtl/aser_master.sv
`timescale 1ns/1ps
module aser_master
  import aser_pkg::*;
#(
  parameter int SAMPLE_W     = 18,
  parameter int NARROW_W     = 16,
  parameter int FRAME_LO     = 256,
  parameter int FRAME_HI     = 384,
  parameter int SLOTS_WIDE   = 64,
  parameter int SLOTS_NARROW = 32
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                ratio_sel_i,
  input  logic [2:0]          fmt_sel_i,
  input  logic                fs_level_i,
  input  logic                load_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                wclk_o,
  output logic                bclk_o,
  output logic                fsync_o,
  output logic                sdata_o,
  output logic                req_o
);

  localparam int SLOT_W = $clog2(SLOTS_WIDE);

  logic [SLOT_W-1:0]   slot;
  logic [2:0]          act_fmt;
  logic                act_lvl;
  logic                left_half, bclk_lvl, frame_start, frame_end;
  logic [SAMPLE_W-1:0] word_l, word_r;
  logic                sd_bit, fs_bit;

  aser_timebase #(
    .FRAME_LO(FRAME_LO), .FRAME_HI(FRAME_HI),
    .SLOTS_WIDE(SLOTS_WIDE), .SLOTS_NARROW(SLOTS_NARROW), .SLOT_W(SLOT_W)
  ) tb_u (
    .clk_i(clk_i), .rst_i(rst_i),
    .ratio_sel_i(ratio_sel_i), .fmt_sel_i(fmt_sel_i), .fs_level_i(fs_level_i),
    .slot_o(slot), .act_fmt_o(act_fmt), .act_lvl_o(act_lvl),
    .left_half_o(left_half), .bclk_lvl_o(bclk_lvl),
    .frame_start_o(frame_start), .frame_end_o(frame_end)
  );

  aser_sample_hold #(.SAMPLE_W(SAMPLE_W)) hold_u (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(load_i),
    .left_i(left_i), .right_i(right_i), .swap_i(frame_end),
    .left_o(word_l), .right_o(word_r)
  );

  aser_slot_map #(
    .SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W),
    .SLOTS_WIDE(SLOTS_WIDE), .SLOTS_NARROW(SLOTS_NARROW), .SLOT_W(SLOT_W)
  ) map_u (
    .slot_i(slot), .left_half_i(left_half), .fmt_i(act_fmt), .fs_level_i(act_lvl),
    .left_w_i(word_l), .right_w_i(word_r), .sd_o(sd_bit), .fs_o(fs_bit)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      wclk_o  <= 1'b0;
      bclk_o  <= 1'b0;
      fsync_o <= 1'b0;
      sdata_o <= 1'b0;
      req_o   <= 1'b0;
    end else begin
      wclk_o  <= left_half;
      bclk_o  <= bclk_lvl;
      fsync_o <= fs_bit;
      sdata_o <= sd_bit;
      req_o   <= frame_start;
    end
  end

endmodule

// File: rtl/aser_master_chk.sv
`timescale 1ns/1ps
module aser_master_chk (
  input logic clk_i,
  input logic rst_i,
  input logic wclk_o,
  input logic bclk_o,
  input logic fsync_o,
  input logic sdata_o,
  input logic req_o
);

  // R4
  req_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    req_o |-> $rose(wclk_o)) else $error("request without word-clock rise");

  // R4
  wclk_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(wclk_o) |-> req_o) else $error("word-clock rise without request");

  // R4
  req_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    req_o |=> !req_o) else $error("request longer than one cycle");

  // R3
  sd_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(sdata_o) |-> !bclk_o) else $error("data moved while bit clock high");

  // R3
  fs_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(fsync_o) |-> !bclk_o) else $error("frame sync moved while bit clock high");

  // R2
  lr_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(wclk_o) |-> !bclk_o) else $error("word clock moved while bit clock high");

  // R3
  bclk_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(bclk_o) |=> bclk_o) else $error("bit clock high phase too short");

endmodule

bind aser_master aser_master_chk chk_u (
  .clk_i(clk_i), .rst_i(rst_i), .wclk_o(wclk_o), .bclk_o(bclk_o),
  .fsync_o(fsync_o), .sdata_o(sdata_o), .req_o(req_o)
);

// File: tb/aser_master_tb.sv
`timescale 1ns/1ps
module aser_master_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ratio_sel = 1'b0;
  logic [2:0]  fmt_sel = 3'd0;
  logic        fs_level = 1'b0;
  logic        load = 1'b0;
  logic [17:0] left_w = '0;
  logic [17:0] right_w = '0;
  logic        wclk, bclk, fsync, sdata, req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  int          m_ph, m_slot;
  logic [2:0]  m_fmt;
  logic        m_ratio, m_lvl;
  logic [17:0] m_l, m_r, p_l, p_r;
  int          n_step;

  // per-signal mismatch record: 0 wclk, 1 bclk, 2 req, 3 sdata, 4 fsync
  int e_cnt[5];
  int e_step[5];
  int e_act[5];
  int e_exp[5];

  always #10 clk = ~clk;

  aser_master dut_i (
    .clk_i(clk), .rst_i(rst), .ratio_sel_i(ratio_sel), .fmt_sel_i(fmt_sel),
    .fs_level_i(fs_level), .load_i(load), .left_i(left_w), .right_i(right_w),
    .wclk_o(wclk), .bclk_o(bclk), .fsync_o(fsync), .sdata_o(sdata), .req_o(req)
  );

  task automatic check(input bit ok, input string req_tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req_tag, what, act, exp);
    end
  endtask

  task automatic fmt_params(input logic [2:0] f, output int start, output int wl,
                            output bit lsb, output bit narrow);
    case (f)
      3'd1: begin start = 14; wl = 18; lsb = 1; narrow = 0; end
      3'd2: begin start = 1;  wl = 16; lsb = 0; narrow = 0; end
      3'd3: begin start = 0;  wl = 16; lsb = 0; narrow = 1; end
      3'd4: begin start = 0;  wl = 16; lsb = 1; narrow = 1; end
      default: begin start = 0; wl = 18; lsb = 0; narrow = 0; end
    endcase
  endtask

  task automatic model_out(output bit w, output bit b, output bit r,
                           output bit d, output bit f, output int per, output int last);
    int start, wl, half, s, k;
    bit lsb, narrow, valid;
    logic [17:0] word;
    fmt_params(m_fmt, start, wl, lsb, narrow);
    per  = (m_ratio ? 384 : 256) / (narrow ? 32 : 64);
    half = narrow ? 16 : 32;
    last = 2 * half - 1;
    w = (m_slot < half);
    b = (m_ph >= per / 2);
    r = (m_ph == 0) && (m_slot == 0);
    s = w ? m_slot : m_slot - half;
    word = w ? m_l : m_r;
    k = s - start;
    valid = (k >= 0) && (k < wl);
    d = valid ? word[lsb ? (18 - wl + k) : (17 - k)] : 1'b0;
    f = m_lvl ? valid : (((s + 1) % half) == start);
  endtask

  task automatic note(input int i, input bit act, input bit exp);
    if (act !== exp) begin
      if (e_cnt[i] == 0) begin
        e_step[i] = n_step;
        e_act[i]  = int'(act);
        e_exp[i]  = int'(exp);
      end
      e_cnt[i]++;
    end
  endtask

  // One master-clock cycle: compare at the falling edge, then advance the model
  // with the inputs that the preceding rising edge saw.
  task automatic step();
    bit w, b, r, d, f;
    int per, last;
    @(negedge clk);
    model_out(w, b, r, d, f, per, last);
    note(0, wclk, w);
    note(1, bclk, b);
    note(2, req, r);
    note(3, sdata, d);
    note(4, fsync, f);
    if (load) begin
      p_l = left_w;
      p_r = right_w;
    end
    if (m_ph == per - 1) begin
      m_ph = 0;
      if (m_slot == last) begin
        m_slot  = 0;
        m_fmt   = fmt_sel;
        m_ratio = ratio_sel;
        m_lvl   = fs_level;
        m_l     = p_l;
        m_r     = p_r;
      end else begin
        m_slot++;
      end
    end else begin
      m_ph++;
    end
    n_step++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // R1: outputs low while reset is held, then model restarts at frame start
  task automatic do_reset(input logic [2:0] f, input logic ra, input logic lv);
    rst = 1'b1;
    load = 1'b0;
    fmt_sel = f;
    ratio_sel = ra;
    fs_level = lv;
    repeat (3) @(negedge clk);
    check({wclk, bclk, fsync, sdata, req} == 5'b0, "R1", "outputs during reset",
          int'({wclk, bclk, fsync, sdata, req}), 0);
    rst = 1'b0;
    m_ph = 0; m_slot = 0;
    m_fmt = f; m_ratio = ra; m_lvl = lv;
    m_l = '0; m_r = '0; p_l = '0; p_r = '0;
    n_step = 0;
    for (int i = 0; i < 5; i++) e_cnt[i] = 0;
  endtask

  task automatic load_pair(input logic [17:0] l, input logic [17:0] r);
    left_w = l;
    right_w = r;
    load = 1'b1;
    step();
    load = 1'b0;
  endtask

  task automatic report(input string t_w, input string t_b, input string t_r,
                        input string t_d, input string t_f);
    string nm[5];
    string tg[5];
    nm = '{"word clock", "bit clock", "request", "serial data", "frame sync"};
    tg = '{t_w, t_b, t_r, t_d, t_f};
    for (int i = 0; i < 5; i++) begin
      if (e_cnt[i] == 0) check(1'b1, tg[i], nm[i], 0, 0);
      else check(1'b0, tg[i], $sformatf("%s cycle %0d (%0d bad)", nm[i], e_step[i], e_cnt[i]),
                 e_act[i], e_exp[i]);
    end
  endtask

  task automatic run_fmt(input logic [2:0] f, input logic ra, input logic lv,
                         input logic [17:0] l, input logic [17:0] r,
                         input string t_d, input string t_f);
    int flen;
    flen = ra ? 384 : 256;
    do_reset(f, ra, lv);
    step();
    load_pair(l, r);
    run(2 * flen + 20);
    report("R2", "R3", "R4", t_d, t_f);
  endtask

  // R13: change format, ratio and sync style mid-frame; applies at next frame
  task automatic t_cfg_change();
    do_reset(3'd0, 1'b0, 1'b0);
    step();
    load_pair(18'h3C5A1, 18'h0F0F3);
    run(100);
    fmt_sel = 3'd4;
    ratio_sel = 1'b1;
    fs_level = 1'b1;
    run(200);
    load_pair(18'h15A3C, 18'h2E817);
    run(2 * 384 + 20);
    report("R13", "R13", "R13", "R13", "R13");
  endtask

  initial begin
    run_fmt(3'd0, 1'b0, 1'b0, 18'h2B5C3, 18'h1A96E, "R5",  "R11");
    run_fmt(3'd1, 1'b1, 1'b1, 18'h2B5C3, 18'h1A96E, "R6",  "R12");
    run_fmt(3'd2, 1'b0, 1'b0, 18'h3F00D, 18'h0C3A5, "R7",  "R11");
    run_fmt(3'd3, 1'b1, 1'b1, 18'h3F00D, 18'h0C3A5, "R8",  "R12");
    run_fmt(3'd4, 1'b0, 1'b0, 18'h24E19, 18'h1B7E6, "R9",  "R11");
    run_fmt(3'd6, 1'b1, 1'b0, 18'h24E19, 18'h1B7E6, "R10", "R11");
    run_fmt(3'd1, 1'b0, 1'b0, 18'h30003, 18'h00000, "R10", "R11");
    t_cfg_change();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule